// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a countdown timer that software programs through a small 32-bit register bus. The bus has an address, a write strobe, write data and a read-data return. Software first picks an operating mode and a start value. It then sets the run bit. From that point the block counts down one step per clock until it reaches zero, and at zero it raises a sticky time-out flag.

What happens after the time-out depends on the mode. In single-shot mode the block clears its own run bit and stops. In repeating mode it reloads the start value and keeps running. An interrupt line is driven by the time-out flag, gated by a mask bit. The flag stays set until software writes a one to a separate clear register. The mode encodings for capture and reserved are stored and read back, but they leave the counter idle.

Reads are combinational: `bus_rdata` reflects the addressed register in the same cycle. Writes take effect at the next rising clock edge.

Top module: `dct_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The registers are: configuration 0x000, mode 0x004, run control 0x00C, mask 0x018, status 0x01C, clear 0x024 and start value 0x028.
- R2: The registers read back only their defined fields, with every other bit reading zero:
  - configuration keeps bits 2:0;
  - mode keeps bits 1:0;
  - run control keeps bit 0;
  - mask keeps bit 0;
  - the start value keeps its low CNT_W bits (16 by default), with the upper bits reading zero;
  - the clear register always reads zero.
- R3: In single-shot mode (mode field 1), suppose a write sets run bit 0 at clock edge k while the timer is stopped, with start value L. Then status bit 0 reads 1 after edge k+L+1 and reads 0 before that edge. After the time-out, the run bit reads 0.
- R4: In repeating mode (mode field 2), a time-out occurs every L+1 edges after the start edge, and the run bit stays 1.
- R5: Writing 1 to bit 0 of the clear register clears status bit 0. Writing 0 to that bit leaves the status unchanged.
- R6: `irq` is high exactly when status bit 0 and mask bit 0 are both 1.
- R7: With the mode field at 0 or 3, setting the run bit never produces a time-out.
- R8: Writes to the mode register or the start-value register are ignored while the run bit is 1.
- R9: When a time-out and a write of 1 to the clear register happen at the same edge, the status bit stays 1.
- R10: Clearing the run bit stops the count, so no time-out follows. Setting the run bit again restarts the count from the full start value.
- R11: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked time-out interrupt |

## Verification
The two functions that can land on the same edge are a counter time-out and a software write to the clear register. The bench runs the timer in repeating mode with a start value of 3, so time-outs fall on a fixed four-edge grid. It first clears the flag away from a time-out, to show that the clear works on its own. It then times a second clear write to land exactly on a later time-out edge. Reading the status on the following cycle judges the collision: the flag must still be 1, because the new time-out takes priority over the clear.

// File: rtl/dct_pkg.sv
package dct_pkg;
   localparam int BUS_W = 32;

   typedef enum logic [1:0] {
      MD_RSVD = 2'd0,
      MD_ONCE = 2'd1,
      MD_LOOP = 2'd2,
      MD_CAPT = 2'd3
   } mode_e;

   localparam logic [7:0] OFS_CFG  = 8'h00;
   localparam logic [7:0] OFS_MODE = 8'h04;
   localparam logic [7:0] OFS_CTRL = 8'h0C;
   localparam logic [7:0] OFS_MASK = 8'h18;
   localparam logic [7:0] OFS_STAT = 8'h1C;
   localparam logic [7:0] OFS_CLR  = 8'h24;
   localparam logic [7:0] OFS_LOAD = 8'h28;
endpackage

// File: rtl/dct_down.sv
module dct_down #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             periodic,
   input  logic [CNT_W-1:0] reload,
   output logic             timeout
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == ZERO);
   assign timeout = run && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
      end else if (start) begin
         cnt_q <= reload;
      end else if (run) begin
         if (!at_zero)      cnt_q <= cnt_q - ONE;
         else if (periodic) cnt_q <= reload;
      end
   end

   // R3
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE));

   // R4
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_zero && periodic) |=> (cnt_q == $past(reload)));
endmodule

// File: rtl/dct_regs.sv
module dct_regs
   import dct_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              timeout,
   output logic              start,
   output logic              run,
   output logic              periodic,
   output logic [CNT_W-1:0]  reload,
   output logic              raw,
   output logic              mask
);
   logic [2:0]       cfg_q;
   mode_e            mode_q;
   logic             en_q;
   logic [CNT_W-1:0] load_q;
   logic             mask_q;
   logic             raw_q;
   logic [BUS_W-1:0] load_rd;

   logic wr_cfg, wr_mode, wr_ctrl, wr_mask, wr_clr, wr_load;
   logic counting_mode;

   assign wr_cfg  = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
   assign wr_mode = bus_we && (bus_addr == ADDR_W'(OFS_MODE));
   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_mask = bus_we && (bus_addr == ADDR_W'(OFS_MASK));
   assign wr_clr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));
   assign wr_load = bus_we && (bus_addr == ADDR_W'(OFS_LOAD));

   assign counting_mode = (mode_q == MD_ONCE) || (mode_q == MD_LOOP);
   assign start    = wr_ctrl && bus_wdata[0] && !en_q;
   assign run      = en_q && counting_mode;
   assign periodic = (mode_q == MD_LOOP);
   assign reload   = load_q;
   assign raw      = raw_q;
   assign mask     = mask_q;

   generate
      if (CNT_W == BUS_W) begin : g_load_full
         assign load_rd = load_q;
      end else begin : g_load_pad
         assign load_rd = {{(BUS_W-CNT_W){1'b0}}, load_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         mode_q <= MD_RSVD;
         en_q   <= 1'b0;
         load_q <= '0;
         mask_q <= 1'b0;
         raw_q  <= 1'b0;
      end else begin
         if (wr_cfg)             cfg_q  <= bus_wdata[2:0];
         if (wr_mode && !en_q)   mode_q <= mode_e'(bus_wdata[1:0]);
         if (wr_load && !en_q)   load_q <= bus_wdata[CNT_W-1:0];
         if (wr_mask)            mask_q <= bus_wdata[0];
         if (timeout && !periodic) en_q <= 1'b0;
         else if (wr_ctrl)          en_q <= bus_wdata[0];
         if (timeout)                       raw_q <= 1'b1;
         else if (wr_clr && bus_wdata[0])   raw_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_CFG):  bus_rdata = {29'b0, cfg_q};
         ADDR_W'(OFS_MODE): bus_rdata = {30'b0, mode_q};
         ADDR_W'(OFS_CTRL): bus_rdata = {31'b0, en_q};
         ADDR_W'(OFS_MASK): bus_rdata = {31'b0, mask_q};
         ADDR_W'(OFS_STAT): bus_rdata = {31'b0, raw_q};
         ADDR_W'(OFS_LOAD): bus_rdata = load_rd;
         default:           bus_rdata = '0;
      endcase
   end

   // R3
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && mode_q == MD_ONCE) |=> !en_q);

   // R9
   timeout_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> raw_q);

   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && bus_wdata[0] && !timeout) |=> !raw_q);

   // R7
   idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !counting_mode) |-> !timeout);

   // R8
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> (mode_q == $past(mode_q) && load_q == $past(load_q)));
endmodule

// File: rtl/dct_timer.sv
module dct_timer
   import dct_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W < 1 || CNT_W > BUS_W) begin : g_bad_cnt_w
         $error("dct_timer: CNT_W must lie in 1..32");
      end
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("dct_timer: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic             start, run, periodic, timeout, raw, mask;
   logic [CNT_W-1:0] reload;

   dct_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .timeout(timeout), .start(start), .run(run),
      .periodic(periodic), .reload(reload),
      .raw(raw), .mask(mask)
   );

   dct_down #(.CNT_W(CNT_W)) u_down (
      .clk(clk), .rst_n(rst_n),
      .start(start), .run(run), .periodic(periodic),
      .reload(reload), .timeout(timeout)
   );

   assign irq = raw & mask;

   // R6
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (raw && mask));
endmodule

// File: tb/dct_timer_bench.sv
module dct_timer_bench;
   localparam real TCK = 8.0;

   localparam logic [7:0] A_CFG  = 8'h00;
   localparam logic [7:0] A_MODE = 8'h04;
   localparam logic [7:0] A_CTRL = 8'h0C;
   localparam logic [7:0] A_MASK = 8'h18;
   localparam logic [7:0] A_STAT = 8'h1C;
   localparam logic [7:0] A_CLR  = 8'h24;
   localparam logic [7:0] A_LOAD = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   typedef struct {
      bit          sel_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   bit    probe = 1'b0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always #(TCK/2) clk = ~clk;

   dct_timer u_dct_timer (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq)
   );

   // monitor: samples a quarter period after each falling edge
   initial begin
      forever begin
         item_t it;
         logic [31:0] act;
         @(negedge clk);
         #2;
         if (probe && sb.size() > 0) begin
            it = sb.pop_front();
            act = it.sel_irq ? {31'b0, irq} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      item_t it;
      it.sel_irq = 1'b0; it.exp = e; it.tag = t;
      sb.push_back(it);
      bus_addr = a; probe = 1'b1;
      @(negedge clk);
      probe = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      item_t it;
      it.sel_irq = 1'b1; it.exp = {31'b0, e}; it.tag = t;
      sb.push_back(it);
      probe = 1'b1;
      @(negedge clk);
      probe = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #(TCK * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset values
      rd(A_CFG, 0, "R1 cfg");   rd(A_MODE, 0, "R1 mode");
      rd(A_CTRL, 0, "R1 ctrl"); rd(A_LOAD, 0, "R1 load");
      rd(A_MASK, 0, "R1 mask"); rd(A_STAT, 0, "R1 stat");
      rd(A_CLR, 0, "R1 clr");   chk_irq(1'b0, "R1 irq");

      // R2 field widths
      wr(A_CFG, 32'hFFFF_FFFF);  rd(A_CFG, 32'h7, "R2 cfg");
      wr(A_CFG, 0);
      wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, 32'h3, "R2 mode");
      wr(A_LOAD, 32'hABCD_1234); rd(A_LOAD, 32'h1234, "R2 load");
      wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, 32'h1, "R2 mask");
      wr(A_MASK, 0);
      wr(A_CLR, 32'hFFFF_FFFF);  rd(A_CLR, 0, "R2 clr");

      // R7 capture and reserved modes stay idle
      wr(A_LOAD, 2);
      wr(A_CTRL, 1); idle(8);
      rd(A_STAT, 0, "R7 capture"); rd(A_CTRL, 1, "R7 ctrl");
      wr(A_CTRL, 0);
      wr(A_MODE, 0);
      wr(A_CTRL, 1); idle(8);
      rd(A_STAT, 0, "R7 reserved");
      wr(A_CTRL, 0);

      // R3 single shot, L=5: flag after edge k+6
      wr(A_MODE, 1); wr(A_LOAD, 5);
      wr(A_CTRL, 1);
      for (int i = 0; i < 6; i++) rd(A_STAT, 0, "R3 early");
      rd(A_STAT, 1, "R3 timeout");
      rd(A_CTRL, 0, "R3 self stop");

      // R6 mask gating
      chk_irq(1'b0, "R6 masked");
      wr(A_MASK, 1);
      chk_irq(1'b1, "R6 unmasked");

      // R5 clear semantics
      wr(A_CLR, 0); rd(A_STAT, 1, "R5 zero write");
      wr(A_CLR, 1); rd(A_STAT, 0, "R5 one write");
      chk_irq(1'b0, "R6 after clear");

      // R11 status write ignored
      wr(A_STAT, 1); rd(A_STAT, 0, "R11 set attempt");

      // R4 repeating, L=3: time-outs at k+4, k+8, k+12
      wr(A_MODE, 2); wr(A_LOAD, 3);
      wr(A_CTRL, 1);
      for (int i = 0; i < 4; i++) rd(A_STAT, 0, "R4 first period");
      rd(A_STAT, 1, "R4 first timeout");
      wr(A_CLR, 1);
      rd(A_STAT, 0, "R4 cleared"); rd(A_STAT, 0, "R4 cleared");
      rd(A_STAT, 1, "R4 second timeout");
      idle(2);
      // R9 clear lands on the k+12 time-out edge
      wr(A_CLR, 1);
      rd(A_STAT, 1, "R9 collision");
      rd(A_CTRL, 1, "R4 still running");

      // R8 lock while running
      wr(A_MODE, 1); rd(A_MODE, 2, "R8 mode locked");
      wr(A_LOAD, 9); rd(A_LOAD, 3, "R8 load locked");
      wr(A_CTRL, 0);
      wr(A_STAT, 0); rd(A_STAT, 1, "R11 clear attempt");
      wr(A_CLR, 1);

      // R10 stop mid-count, then full restart, L=6
      wr(A_MODE, 1); wr(A_LOAD, 6);
      wr(A_CTRL, 1); idle(3);
      wr(A_CTRL, 0); idle(10);
      rd(A_STAT, 0, "R10 stopped"); rd(A_CTRL, 0, "R10 ctrl");
      wr(A_CTRL, 1);
      for (int i = 0; i < 7; i++) rd(A_STAT, 0, "R10 full restart");
      rd(A_STAT, 1, "R10 timeout");
      chk_irq(1'b1, "R6 raised");

      idle(3);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule